// File: doc/BRIEF.md
# Programmable Stride Wrap Counter

This block generates a loop index on chip, so the host does not need to stream one. Before a stream begins, the host sets a wrap limit and a stride on two input buses and pulses a start strobe. The start strobe copies both values into shadow registers. From then on the count moves by the stride on each enabled cycle. When the count equals the limit, it returns to zero. New values on the parameter buses during a stream have no effect until the next start strobe.

A build-time switch removes the enable. With the enable removed, the counter advances on every cycle. With a stride of one it then produces 0, 1, 2 and so on, one value per clock. The count width is a parameter with a default of 32 bits. If a stride jumps past the limit without landing on it, the count wraps modulo two to the width.

Top module: `stride_wrap_counter`

## Requirements
- R1: A synchronous reset sets count to zero and valid to zero on the next clock edge.
- R2: A start pulse captures max_in and step_in into the shadow registers. After that edge, count is zero and valid is one. Start takes priority over the wrap, step and hold rules.
- R3: While valid is one and count equals the captured limit, count is zero after the next edge, whatever the level of en.
- R4: While valid is one, count differs from the limit and the counter is enabled, count becomes count plus the captured stride, modulo 2^W.
- R5: While valid is one, count differs from the limit and en is low (with HAS_EN=1), count holds its value.
- R6: Changes on max_in or step_in without a start pulse have no effect on the count sequence.
- R7: With HAS_EN=0, en is ignored and the counter advances on every cycle. With a stride of 1 and a limit of 5, it produces 0,1,2,3,4,5,0.
- R8: A start pulse during a running stream restarts the count at zero with the newly captured parameters.
- R9: Before the first start after reset, valid stays zero and count stays zero, whatever en does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable (ignored when HAS_EN=0) |
| start | input | 1 | Captures the parameters and restarts the count |
| max_in | input | W | Wrap limit, captured on start |
| step_in | input | W | Stride, captured on start |
| count | output | W | Current index |
| valid | output | 1 | High once a stream has been started |

## Verification
The bound checker tests the following on every clock edge:
- the effect of reset and of start,
- the wrap to zero at the limit,
- the step and hold rules against the captured stride,
- the stability of the shadow registers between start pulses.

Other behaviour shows only in the bench scenarios, which compare the outputs with a reference model:
- a stride that jumps past the limit and wraps modulo 2^W,
- a sequence that ignores parameter changes made in mid-stream,
- a restart with new parameters,
- the free-running counter with HAS_EN=0.

The limit and stride values are random, and the enable patterns are random.

// File: rtl/stride_wrap_counter.sv
module stride_wrap_counter #(
  parameter int W = 32,
  parameter bit HAS_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] max_in,
  input  logic [W-1:0] step_in,
  output logic [W-1:0] count,
  output logic         valid
);
  logic [W-1:0] max_q, step_q, cnt_q;
  logic         run_q;
  logic         adv;

  assign adv   = HAS_EN ? en : 1'b1;
  assign count = cnt_q;
  assign valid = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q  <= '0;
      step_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else if (start) begin
      max_q  <= max_in;
      step_q <= step_in;
      cnt_q  <= '0;
      run_q  <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == max_q) cnt_q <= '0;
      else if (adv)       cnt_q <= cnt_q + step_q;
    end
  end
endmodule

module stride_wrap_counter_chk #(
  parameter int W = 32,
  parameter bit HAS_EN = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         start,
  input logic [W-1:0] count,
  input logic         valid,
  input logic [W-1:0] max_q,
  input logic [W-1:0] step_q
);
  logic go;
  assign go = en || !HAS_EN;

  p_reset_r1: assert property (@(posedge clk) rst |=> (count == '0) && !valid);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (count == '0) && valid);
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && !start && count == max_q) |=> count == '0);
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && !start && count != max_q && go) |=> count == $past(count) + $past(step_q));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (valid && !start && count != max_q && !go) |=> $stable(count));
  p_shadow_r6: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(max_q) && $stable(step_q));
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!valid && !start) |=> !valid && count == '0);
endmodule

bind stride_wrap_counter stride_wrap_counter_chk #(.W(W), .HAS_EN(HAS_EN)) u_chk (
  .clk(clk), .rst(rst), .en(en), .start(start), .count(count),
  .valid(valid), .max_q(max_q), .step_q(step_q)
);

// File: tb/stride_wrap_counter_test.sv
module stride_wrap_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int FW = 8;

  typedef struct {
    logic [W-1:0]  cnt;
    logic          val;
    logic [FW-1:0] fcnt;
    string         tag;
  } item_t;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, start = 1'b0;
  logic [W-1:0] max_in = '0, step_in = '0;
  logic [W-1:0] count;
  logic valid;
  logic [FW-1:0] fcount;
  logic fvalid;

  int errors = 0, checks = 0;
  item_t q[$];

  logic [W-1:0] m_cnt = '0, m_max = '0, m_step = '0;
  logic m_val = 1'b0;
  logic [FW-1:0] f_cnt = '0;
  logic f_val = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stride_wrap_counter #(.W(W)) uut (
    .clk(clk), .rst(rst), .en(en), .start(start), .max_in(max_in),
    .step_in(step_in), .count(count), .valid(valid));

  stride_wrap_counter #(.W(FW), .HAS_EN(1'b0)) uut_free (
    .clk(clk), .rst(rst), .en(en), .start(start), .max_in(FW'(5)),
    .step_in(FW'(1)), .count(fcount), .valid(fvalid));

  task automatic drive(input logic r, input logic s, input logic e,
                       input logic [W-1:0] mx, input logic [W-1:0] st);
    item_t it;
    @(negedge clk);
    rst = r; start = s; en = e; max_in = mx; step_in = st;
    if (r) begin
      m_cnt = '0; m_val = 1'b0; m_max = '0; m_step = '0; it.tag = "R1";
    end else if (s) begin
      it.tag = m_val ? "R8" : "R2";
      m_max = mx; m_step = st; m_cnt = '0; m_val = 1'b1;
    end else if (!m_val) begin
      it.tag = "R9";
    end else if (m_cnt == m_max) begin
      m_cnt = '0; it.tag = "R3";
    end else if (e) begin
      m_cnt = m_cnt + m_step;
      it.tag = (mx != m_max || st != m_step) ? "R6" : "R4";
    end else begin
      it.tag = (mx != m_max || st != m_step) ? "R6" : "R5";
    end
    if (r) begin f_cnt = '0; f_val = 1'b0; end
    else if (s) begin f_cnt = '0; f_val = 1'b1; end
    else if (f_val) f_cnt = (f_cnt == FW'(5)) ? '0 : f_cnt + 1'b1;
    it.cnt = m_cnt; it.val = m_val; it.fcnt = f_cnt;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (count !== it.cnt || valid !== it.val) begin
        errors++;
        $display("FAIL %s: count=%0d valid=%0b expected count=%0d valid=%0b",
                 it.tag, count, valid, it.cnt, it.val);
      end
      checks++;
      if (fcount !== it.fcnt) begin
        errors++;
        $display("FAIL R7: free count=%0d expected %0d", fcount, it.fcnt);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(1, 0, 0, '0, '0);
    drive(1, 0, 0, '0, '0);
    // R9: idle with enable high, no start
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 7, 1);
    // R2 then R4/R3: limit 9 stride 3, R7 free counter runs alongside
    drive(0, 1, 0, 9, 3);
    for (int i = 0; i < 10; i++) drive(0, 0, 1, 9, 3);
    // R5: hold with enable low
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 9, 3);
    // R6: parameter buses change without start
    for (int i = 0; i < 8; i++) drive(0, 0, 1, 2, 1);
    // R8: restart mid-stream with limit 0 (stays at zero)
    drive(0, 1, 1, 0, 4);
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 0, 4);
    // R4: stride jumps past limit and wraps modulo 2^W
    drive(0, 1, 1, 5, 32'h8000_0000);
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 5, 32'h8000_0000);
    // stride zero holds below limit
    drive(0, 1, 1, 3, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 3, 0);
    // random streams
    for (int s = 0; s < 40; s++) begin
      logic [W-1:0] mx, st;
      st = W'($urandom_range(1, 4));
      mx = st * W'($urandom_range(0, 6));
      drive(0, 1, $urandom_range(0, 1) == 1, mx, st);
      for (int i = 0; i < 25; i++)
        drive(0, $urandom_range(0, 60) == 0, $urandom_range(0, 3) != 0,
              W'($urandom), W'($urandom));
    end
    // R1: reset mid-stream
    drive(1, 0, 1, 4, 1);
    drive(0, 0, 1, 4, 1);
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule